// File: doc/BRIEF.md
# MMU Fault Status Encoder

This block sits between an address-translation lookup array and the exception controller of a processor core. For each access presented on its request inputs, it decides whether translation applies at all. If it does not apply, the address passes straight through with full access rights. If it applies and the lookup hit, the block forms the physical address from the matched page bases. If the lookup missed or reported a protection violation, the block raises a one-cycle fault pulse, captures the faulting address and composes the exception status code.

Translation is used only when three things hold: the core is built with an MMU, the configuration words agree that the MMU is present, and the virtual-mode bit of the machine status register is set. When the extended configuration flag is set, the extended configuration word must also report the MMU. A fault that arrives while an MMU exception is already being serviced is flagged as a fatal recursive fault. All results appear on registered outputs one cycle after the request.

Top module: `mmu_fault_enc`

## Requirements
- R1: When translation does not apply, a request produces `pa_valid`=1, `pa_bypass`=1 and `pa_addr` equal to `req_addr`, and no fault, whatever the lookup result.
- R2: Translation applies only when `cfg_has_mmu`=1, `msr_vm`=1, and not (`cfg_full`=1 with `cfg_ext_mmu`=0).
- R3: On a translated hit, `pa_addr` = `lu_pbase` + (page-aligned `req_addr` − `lu_vbase`), with the low PAGE_BITS offset bits (default 10, a 1 KiB page) taken unchanged from `req_addr`, and `pa_bypass`=0.
- R4: On a fault `ear` is loaded with the full `req_addr`; at all other times `ear` holds its value.
- R5: A protection fault (`lu_hit`=0, `lu_prot`=1) sets `esr` to 17 when `req_kind` is fetch (2'b10) and to 16 otherwise.
- R6: A translation miss (`lu_hit`=0, `lu_prot`=0) sets `esr` to 19 for a fetch and to 18 otherwise.
- R7: `esr` bit 10 is set on a fault exactly when `req_kind` is store (2'b01); load is 2'b00, and 2'b11 counts as a load.
- R8: `recur_err` pulses together with `fault` when `mmu_exc_busy`=1 at the time of the faulting request, and never without `fault`.
- R9: Outputs register one cycle after `req_valid`; `fault` and `pa_valid` last one cycle per request, are never both high, and stay low in cycles that follow no request.
- R10: After reset, `pa_valid`, `pa_bypass`, `pa_addr`, `fault`, `recur_err`, `ear` and `esr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | AW | Virtual address of the access |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| lu_hit | input | 1 | Lookup found a usable entry |
| lu_prot | input | 1 | On a non-hit: 1 protection violation, 0 miss |
| lu_vbase | input | AW | Matched virtual page base |
| lu_pbase | input | AW | Matched physical page base |
| cfg_has_mmu | input | 1 | Core built with an MMU |
| cfg_full | input | 1 | Extended configuration word is valid |
| cfg_ext_mmu | input | 1 | Extended configuration word reports the MMU |
| msr_vm | input | 1 | Virtual mode enabled in the status register |
| mmu_exc_busy | input | 1 | An MMU exception is being serviced |
| pa_valid | output | 1 | Physical address result is valid |
| pa_bypass | output | 1 | Result came from pass-through with full rights |
| pa_addr | output | AW | Physical address |
| fault | output | 1 | One-cycle fault pulse |
| recur_err | output | 1 | Fault occurred during an MMU exception |
| ear | output | AW | Captured faulting address |
| esr | output | ESR_W | Exception status code |

## Verification
The hardest cases to reach are the configuration corners of R2: the MMU is built in but the extended word disowns it, or virtual mode is off. In those cases a lookup that reports a miss must be ignored completely. The bench drives a miss with deliberately wrong page bases under each such setting and checks for a pass-through result with no fault. It also checks that `ear` and `esr` still hold the values from the earlier fault. Back-to-back faulting requests are also issued, to show that each request gives its own fault pulse and that the captured status is overwritten.

// File: rtl/mfe_pkg.sv
package mfe_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'b00,
        KIND_STORE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_RSVD  = 2'b11
    } acc_kind_e;

    localparam int unsigned CODE_PROT_DATA  = 16;
    localparam int unsigned CODE_PROT_FETCH = 17;
    localparam int unsigned CODE_MISS_DATA  = 18;
    localparam int unsigned CODE_MISS_FETCH = 19;
    localparam int unsigned STORE_FLAG_BIT  = 10;

endpackage

// File: rtl/mfe_avail.sv
module mfe_avail (
    input  logic cfg_has_mmu,
    input  logic cfg_full,
    input  logic cfg_ext_mmu,
    input  logic msr_vm,
    output logic xlate_on
);
    logic present;

    always_comb begin
        present  = cfg_has_mmu && !(cfg_full && !cfg_ext_mmu);
        xlate_on = present && msr_vm;
    end
endmodule

// File: rtl/mfe_xlate.sv
module mfe_xlate #(
    parameter int unsigned AW        = 32,
    parameter int unsigned PAGE_BITS = 10
) (
    input  logic [AW-1:0] vaddr,
    input  logic [AW-1:0] vbase,
    input  logic [AW-1:0] pbase,
    output logic [AW-1:0] paddr
);
    localparam logic [AW-1:0] OFF_MASK = AW'((64'd1 << PAGE_BITS) - 64'd1);

    logic [AW-1:0] vpage;
    logic [AW-1:0] ppage;

    always_comb begin
        vpage = vaddr & ~OFF_MASK;
        ppage = pbase + (vpage - vbase);
        paddr = (ppage & ~OFF_MASK) | (vaddr & OFF_MASK);
    end
endmodule

// File: rtl/mfe_code.sv
module mfe_code #(
    parameter int unsigned ESR_W = 32
) (
    input  logic             prot_err,
    input  logic [1:0]       kind,
    output logic [ESR_W-1:0] code
);
    import mfe_pkg::*;

    logic is_fetch;
    logic is_store;

    always_comb begin
        is_fetch = (kind == KIND_FETCH);
        is_store = (kind == KIND_STORE);
        if (prot_err)
            code = is_fetch ? ESR_W'(CODE_PROT_FETCH) : ESR_W'(CODE_PROT_DATA);
        else
            code = is_fetch ? ESR_W'(CODE_MISS_FETCH) : ESR_W'(CODE_MISS_DATA);
        code[STORE_FLAG_BIT] = is_store;
    end
endmodule

// File: rtl/mmu_fault_enc.sv
module mmu_fault_enc #(
    parameter int unsigned AW        = 32,
    parameter int unsigned PAGE_BITS = 10,
    parameter int unsigned ESR_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [1:0]       req_kind,
    input  logic             lu_hit,
    input  logic             lu_prot,
    input  logic [AW-1:0]    lu_vbase,
    input  logic [AW-1:0]    lu_pbase,
    input  logic             cfg_has_mmu,
    input  logic             cfg_full,
    input  logic             cfg_ext_mmu,
    input  logic             msr_vm,
    input  logic             mmu_exc_busy,
    output logic             pa_valid,
    output logic             pa_bypass,
    output logic [AW-1:0]    pa_addr,
    output logic             fault,
    output logic             recur_err,
    output logic [AW-1:0]    ear,
    output logic [ESR_W-1:0] esr
);
    typedef struct packed {
        logic             pa_valid;
        logic             pa_bypass;
        logic [AW-1:0]    pa_addr;
        logic             fault;
        logic             recur;
        logic [AW-1:0]    ear;
        logic [ESR_W-1:0] esr;
    } st_t;

    st_t st_d, st_q;

    logic             xlate_on;
    logic [AW-1:0]    xl_addr;
    logic [ESR_W-1:0] fault_code;

    mfe_avail u_avail (
        .cfg_has_mmu (cfg_has_mmu),
        .cfg_full    (cfg_full),
        .cfg_ext_mmu (cfg_ext_mmu),
        .msr_vm      (msr_vm),
        .xlate_on    (xlate_on)
    );

    mfe_xlate #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_xlate (
        .vaddr (req_addr),
        .vbase (lu_vbase),
        .pbase (lu_pbase),
        .paddr (xl_addr)
    );

    mfe_code #(.ESR_W(ESR_W)) u_code (
        .prot_err (lu_prot),
        .kind     (req_kind),
        .code     (fault_code)
    );

    always_comb begin
        st_d           = st_q;
        st_d.pa_valid  = 1'b0;
        st_d.pa_bypass = 1'b0;
        st_d.fault     = 1'b0;
        st_d.recur     = 1'b0;
        if (req_valid) begin
            if (!xlate_on) begin
                st_d.pa_valid  = 1'b1;
                st_d.pa_bypass = 1'b1;
                st_d.pa_addr   = req_addr;
            end else if (lu_hit) begin
                st_d.pa_valid  = 1'b1;
                st_d.pa_addr   = xl_addr;
            end else begin
                st_d.fault     = 1'b1;
                st_d.recur     = mmu_exc_busy;
                st_d.ear       = req_addr;
                st_d.esr       = fault_code;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pa_valid  = st_q.pa_valid;
    assign pa_bypass = st_q.pa_bypass;
    assign pa_addr   = st_q.pa_addr;
    assign fault     = st_q.fault;
    assign recur_err = st_q.recur;
    assign ear       = st_q.ear;
    assign esr       = st_q.esr;
endmodule

// File: rtl/mfe_checker.sv
module mfe_checker #(
    parameter int unsigned AW    = 32,
    parameter int unsigned ESR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [AW-1:0]    req_addr,
    input logic [1:0]       req_kind,
    input logic             pa_valid,
    input logic             pa_bypass,
    input logic [AW-1:0]    pa_addr,
    input logic             fault,
    input logic             recur_err,
    input logic [AW-1:0]    ear,
    input logic [ESR_W-1:0] esr
);
    AST_BYPASS_PASSES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_valid && pa_bypass) |-> pa_addr == $past(req_addr)); // R1
    AST_EAR_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ear == $past(req_addr)); // R4
    AST_EAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> $stable(ear)); // R4
    AST_STORE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> esr[10] == ($past(req_kind) == 2'b01)); // R7
    AST_RECUR_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        recur_err |-> fault); // R8
    AST_OUT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fault || pa_valid) |-> $past(req_valid)); // R9
    AST_FAULT_XOR_PA: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && pa_valid)); // R9
endmodule

bind mmu_fault_enc mfe_checker #(.AW(AW), .ESR_W(ESR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_kind  (req_kind),
    .pa_valid  (pa_valid),
    .pa_bypass (pa_bypass),
    .pa_addr   (pa_addr),
    .fault     (fault),
    .recur_err (recur_err),
    .ear       (ear),
    .esr       (esr)
);

// File: tb/sim_mmu_fault_enc.sv
module sim_mmu_fault_enc;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int ESR_W = 32;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_kind = 2'b00;
    logic lu_hit = 0, lu_prot = 0;
    logic [AW-1:0] lu_vbase = '0, lu_pbase = '0;
    logic cfg_has_mmu = 1, cfg_full = 0, cfg_ext_mmu = 0, msr_vm = 1, mmu_exc_busy = 0;
    logic pa_valid, pa_bypass, fault, recur_err;
    logic [AW-1:0] pa_addr, ear;
    logic [ESR_W-1:0] esr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_fault_enc u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .lu_hit(lu_hit), .lu_prot(lu_prot),
        .lu_vbase(lu_vbase), .lu_pbase(lu_pbase), .cfg_has_mmu(cfg_has_mmu),
        .cfg_full(cfg_full), .cfg_ext_mmu(cfg_ext_mmu), .msr_vm(msr_vm),
        .mmu_exc_busy(mmu_exc_busy), .pa_valid(pa_valid), .pa_bypass(pa_bypass),
        .pa_addr(pa_addr), .fault(fault), .recur_err(recur_err), .ear(ear), .esr(esr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic has, input logic full, input logic ext, input logic vm);
        cfg_has_mmu = has; cfg_full = full; cfg_ext_mmu = ext; msr_vm = vm;
    endtask

    // Presents one request at a falling edge; results are sampled at the next falling edge.
    task automatic issue(input logic [AW-1:0] a, input logic [1:0] k, input logic hit,
                         input logic prot, input logic [AW-1:0] vb, input logic [AW-1:0] pb);
        @(negedge clk);
        req_valid = 1; req_addr = a; req_kind = k;
        lu_hit = hit; lu_prot = prot; lu_vbase = vb; lu_pbase = pb;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic t_reset();
        chk("R10 pa_valid", pa_valid, 0);
        chk("R10 pa_bypass", pa_bypass, 0);
        chk("R10 pa_addr", pa_addr, 0);
        chk("R10 fault", fault, 0);
        chk("R10 recur_err", recur_err, 0);
        chk("R10 ear", ear, 0);
        chk("R10 esr", esr, 0);
    endtask

    task automatic t_hit();
        set_cfg(1, 0, 0, 1);
        issue(32'h0001_23A5, 2'b00, 1, 0, 32'h0001_2000, 32'h8000_4000);
        chk("R3 pa_valid", pa_valid, 1);
        chk("R3 pa_bypass", pa_bypass, 0);
        chk("R3 pa_addr same page", pa_addr, 32'h8000_43A5);
        chk("R9 no fault on hit", fault, 0);
        issue(32'h0001_2C07, 2'b10, 1, 0, 32'h0001_0000, 32'h4000_0000);
        chk("R3 pa_addr offset page", pa_addr, 32'h4000_2C07);
        @(negedge clk);
        chk("R9 pa_valid one cycle", pa_valid, 0);
    endtask

    task automatic t_faults();
        set_cfg(1, 1, 1, 1);
        issue(32'hDEAD_BEE1, 2'b00, 0, 1, '0, '0);
        chk("R9 fault pulse", fault, 1);
        chk("R9 no pa on fault", pa_valid, 0);
        chk("R4 ear", ear, 32'hDEAD_BEE1);
        chk("R5 prot load", esr, 16);
        chk("R8 no recur", recur_err, 0);
        issue(32'h0000_0104, 2'b10, 0, 1, '0, '0);
        chk("R5 prot fetch", esr, 17);
        issue(32'h0000_0208, 2'b01, 0, 1, '0, '0);
        chk("R7 prot store", esr, 32'd16 | 32'd1024);
        issue(32'h0000_0300, 2'b00, 0, 0, '0, '0);
        chk("R6 miss load", esr, 18);
        issue(32'h0000_0400, 2'b10, 0, 0, '0, '0);
        chk("R6 miss fetch", esr, 19);
        issue(32'h0000_0504, 2'b01, 0, 0, '0, '0);
        chk("R7 miss store", esr, 32'd18 | 32'd1024);
        chk("R4 ear store", ear, 32'h0000_0504);
        issue(32'h0000_0600, 2'b11, 0, 0, '0, '0);
        chk("R7 kind 11 as load", esr, 18);
        @(negedge clk);
        chk("R9 fault one cycle", fault, 0);
        chk("R4 ear holds", ear, 32'h0000_0600);
    endtask

    task automatic t_back_to_back();
        set_cfg(1, 0, 0, 1);
        @(negedge clk);
        req_valid = 1; req_addr = 32'h1111_0000; req_kind = 2'b00; lu_hit = 0; lu_prot = 0;
        @(negedge clk);
        chk("R9 first fault", fault, 1);
        chk("R4 first ear", ear, 32'h1111_0000);
        req_addr = 32'h2222_0000; req_kind = 2'b10; lu_prot = 1;
        @(negedge clk);
        req_valid = 0;
        chk("R9 second fault", fault, 1);
        chk("R4 second ear", ear, 32'h2222_0000);
        chk("R5 second esr", esr, 17);
    endtask

    task automatic t_recursive();
        set_cfg(1, 0, 0, 1);
        mmu_exc_busy = 1;
        issue(32'h0000_0ABC, 2'b00, 0, 0, '0, '0);
        chk("R8 recur_err", recur_err, 1);
        chk("R8 fault with recur", fault, 1);
        issue(32'h0000_0ABC, 2'b00, 1, 0, 32'h0, 32'h0);
        chk("R8 no recur on hit", recur_err, 0);
        mmu_exc_busy = 0;
    endtask

    task automatic t_bypass();
        logic [AW-1:0] ear_keep;
        logic [ESR_W-1:0] esr_keep;
        ear_keep = ear; esr_keep = esr;
        set_cfg(1, 1, 0, 1); // R2: extended word disowns the MMU
        issue(32'h1234_5678, 2'b01, 0, 0, 32'h0000_1000, 32'h9000_0000);
        chk("R2 ext disown bypass", pa_bypass, 1);
        chk("R1 pass addr", pa_addr, 32'h1234_5678);
        chk("R1 no fault", fault, 0);
        chk("R1 ear kept", ear, ear_keep);
        chk("R1 esr kept", esr, esr_keep);
        set_cfg(1, 0, 1, 0); // R2: virtual mode off
        issue(32'h0000_0FFF, 2'b10, 0, 1, '0, '0);
        chk("R2 vm off bypass", pa_bypass, 1);
        chk("R1 vm off addr", pa_addr, 32'h0000_0FFF);
        chk("R1 vm off no fault", fault, 0);
        set_cfg(0, 0, 0, 1); // R2: no MMU built
        issue(32'hCAFE_0001, 2'b00, 1, 0, 32'h0, 32'h7000_0000);
        chk("R2 no mmu bypass", pa_bypass, 1);
        chk("R1 no mmu addr", pa_addr, 32'hCAFE_0001);
        set_cfg(1, 1, 1, 1); // R2: all conditions met, hit translates
        issue(32'h0000_0C05, 2'b00, 1, 0, 32'h0000_0C00, 32'h0005_0000);
        chk("R2 full cfg translates", pa_bypass, 0);
        chk("R3 full cfg addr", pa_addr, 32'h0005_0005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        @(negedge clk);
        chk("R9 idle no output", pa_valid | fault, 0);
        t_hit();
        t_faults();
        t_back_to_back();
        t_recursive();
        t_bypass();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule